// File: doc/BRIEF.md
# Tag-Only Issue Scheduler with Latency Countdown Wakeup

This block is a small pool of scheduling slots in an out-of-order core. Each slot holds a waiting instruction described only by its opcode, its destination tag and two source tags, each source carrying a ready flag. No operand data is stored. A slot becomes eligible once both of its sources are ready. A priority picker then issues one eligible slot per cycle. The issued opcode, destination tag and slot index go out to a later stage, which reads the register file.

Wakeup does not wait for results to be written back. Each issued instruction pushes its destination tag into a delay lane chosen by its opcode latency, and the tag comes out on a broadcast lane exactly that many cycles later. Every slot compares its source tags against all broadcast lanes. A dependent instruction can therefore issue in the cycle right after a one-cycle producer. Loads are scheduled as if they hit the cache. A flush, raised on a misprediction, empties every slot in one cycle.

Each slot runs a three-state machine: SLOT_FREE (empty), SLOT_WAIT (occupied, at least one source not ready) and SLOT_ARMED (occupied, both sources ready). The transitions are:
- alloc_wait: SLOT_FREE to SLOT_WAIT, on an allocation with a missing source.
- alloc_armed: SLOT_FREE to SLOT_ARMED, on an allocation whose sources are ready at entry or are woken in that same cycle.
- wake: SLOT_WAIT to SLOT_ARMED, when a broadcast makes the last source ready.
- issue_free: SLOT_WAIT or SLOT_ARMED to SLOT_FREE, when the slot is granted.
- flush_free: any state to SLOT_FREE, on flush.

Top module: `sched_core`

## Requirements
- R1: While reset is held and in the first cycle after it, issue_valid and every bcast_valid bit are 0 and alloc_ready is 1.
- R2: An issued instruction presents on issue_op and issue_dst the opcode and destination tag it was allocated with.
- R3: Opcode encodings are 0 = ALU (latency 1), 1 = LOAD (latency 2), 2 = MUL (latency 3) and 3 = DIV (latency 4). An instruction issued in cycle t drives its destination tag on broadcast lane L-1 (bcast_valid bit L-1, bcast_tag bits [L*TAG_W-1:(L-1)*TAG_W]) in cycle t+L, where L is its latency. The broadcast is valid only in that cycle.
- R4: A source whose tag equals the tag on any valid broadcast lane becomes ready. A slot requests issue in the first cycle in which both of its sources are ready, including the cycle in which the last wakeup arrives.
- R5: At most one slot is issued per cycle: the requesting slot with the lowest index, reported on issue_slot. That slot is freed at the clock edge that ends the cycle, so slots can be freed out of allocation order.
- R6: alloc_ready is 1 while any slot is free. An allocation fills the lowest free slot, and a slot freed by issue is not refilled in the same cycle. An alloc_valid presented while alloc_ready is 0 is ignored.
- R7: A flush empties all slots at the next edge. An allocation or a grant in the flush cycle is dropped: issue_valid is 0 in that cycle. Tags already in the delay lanes are still broadcast.
- R8: A load is scheduled for a cache hit. Its consumer is woken two cycles after the load issues, never later.
- R9: A consumer of an ALU instruction allocated before the producer's broadcast cycle issues exactly one cycle after the producer, if no lower slot competes.
- R10: A broadcast in the same cycle as the allocation of a consumer whose source matches makes that source ready.
- R11: A source flagged ready at allocation needs no wakeup. An instruction allocated with both sources ready into an otherwise idle pool issues in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Misprediction flush: empty all slots |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | 2 | Opcode of the instruction to allocate |
| alloc_dst | input | TAG_W | Destination tag |
| alloc_src1 | input | TAG_W | First source tag |
| alloc_src1_rdy | input | 1 | First source already available |
| alloc_src2 | input | TAG_W | Second source tag |
| alloc_src2_rdy | input | 1 | Second source already available |
| alloc_ready | output | 1 | At least one slot is free |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_op | output | 2 | Opcode of the issued instruction |
| issue_dst | output | TAG_W | Destination tag of the issued instruction |
| issue_slot | output | $clog2(ENTRIES) | Index of the issued slot |
| bcast_valid | output | 4 | Per-latency broadcast lane valid |
| bcast_tag | output | 4*TAG_W | Per-latency broadcast tags, lane 0 in the low bits |

## Verification
Wakeup and allocation can fall in the same cycle. The bench provokes this by allocating a consumer in exactly the cycle in which its producer's tag leaves a delay lane. A consumer that misses this wakeup would never issue, because no later broadcast of that tag follows. The check therefore requires the consumer to issue two cycles after the producer. Issue and allocation also meet in one cycle under random traffic, and a cycle-level reference model written from the requirements judges every output in every cycle, including which slot a same-cycle allocation lands in.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int NLANE = 4;

    typedef enum logic [1:0] {
        OP_ALU  = 2'd0,
        OP_LOAD = 2'd1,
        OP_MUL  = 2'd2,
        OP_DIV  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_ARMED = 2'd2
    } slot_st_e;

    // scheduled latency per opcode; loads assume a cache hit
    function automatic int unsigned op_latency(input logic [1:0] op);
        case (op)
            OP_ALU:  op_latency = 1;
            OP_LOAD: op_latency = 2;
            OP_MUL:  op_latency = 3;
            default: op_latency = 4;
        endcase
    endfunction

endpackage

// File: rtl/sched_pick.sv
module sched_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx,
    output logic          any
);
    // lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        onehot = '0;
        idx    = '0;
        any    = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                idx       = IW'(i);
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sched_lane.sv
module sched_lane #(
    parameter int TAG_W = 5,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_v,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_v,
    output logic [TAG_W-1:0] out_tag
);
    logic [DEPTH-1:0] stg_v;
    logic [TAG_W-1:0] stg_t [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v <= '0;
            for (int k = 0; k < DEPTH; k++) stg_t[k] <= '0;
        end else begin
            stg_v[0] <= in_v;
            stg_t[0] <= in_tag;
            for (int k = 1; k < DEPTH; k++) begin
                stg_v[k] <= stg_v[k-1];
                stg_t[k] <= stg_t[k-1];
            end
        end
    end

    assign out_v   = stg_v[DEPTH-1];
    assign out_tag = stg_t[DEPTH-1];
endmodule

// File: rtl/sched_slot.sv
module sched_slot
    import sched_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int NL    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                alloc_en,
    input  logic [1:0]          a_op,
    input  logic [TAG_W-1:0]    a_dst,
    input  logic [TAG_W-1:0]    a_s1,
    input  logic                a_r1,
    input  logic [TAG_W-1:0]    a_s2,
    input  logic                a_r2,
    input  logic                grant,
    input  logic [NL-1:0]       bc_valid,
    input  logic [NL*TAG_W-1:0] bc_tag,
    output logic                busy,
    output logic                req,
    output logic [1:0]          op_q,
    output logic [TAG_W-1:0]    dst_q
);
    slot_st_e         st, st_nx;
    logic [TAG_W-1:0] s1_q, s2_q;
    logic             r1_q, r2_q;
    logic             eff1, eff2, in1, in2;

    function automatic logic tag_hit(input logic [TAG_W-1:0] tag);
        tag_hit = 1'b0;
        for (int g = 0; g < NL; g++)
            if (bc_valid[g] && (bc_tag[g*TAG_W +: TAG_W] == tag)) tag_hit = 1'b1;
    endfunction

    assign in1  = a_r1 | tag_hit(a_s1);
    assign in2  = a_r2 | tag_hit(a_s2);
    assign eff1 = r1_q | tag_hit(s1_q);
    assign eff2 = r2_q | tag_hit(s2_q);

    // next-state logic
    always_comb begin
        st_nx = st;
        if (flush) begin
            st_nx = SLOT_FREE;
        end else begin
            unique case (st)
                SLOT_FREE:  if (alloc_en) st_nx = (in1 && in2) ? SLOT_ARMED : SLOT_WAIT;
                SLOT_WAIT:  if (grant) st_nx = SLOT_FREE;
                            else if (eff1 && eff2) st_nx = SLOT_ARMED;
                SLOT_ARMED: if (grant) st_nx = SLOT_FREE;
                default:    st_nx = SLOT_FREE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SLOT_FREE;
        else        st <= st_nx;
    end

    // payload and ready flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            dst_q <= '0;
            s1_q  <= '0;
            s2_q  <= '0;
            r1_q  <= 1'b0;
            r2_q  <= 1'b0;
        end else if (st == SLOT_FREE && alloc_en) begin
            op_q  <= a_op;
            dst_q <= a_dst;
            s1_q  <= a_s1;
            s2_q  <= a_s2;
            r1_q  <= in1;
            r2_q  <= in2;
        end else if (st == SLOT_WAIT) begin
            r1_q  <= eff1;
            r2_q  <= eff2;
        end
    end

    // outputs
    always_comb begin
        busy = (st != SLOT_FREE);
        req  = busy && eff1 && eff2;
    end
endmodule

// File: rtl/sched_core.sv
module sched_core
    import sched_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         alloc_valid,
    input  logic [1:0]                   alloc_op,
    input  logic [TAG_W-1:0]             alloc_dst,
    input  logic [TAG_W-1:0]             alloc_src1,
    input  logic                         alloc_src1_rdy,
    input  logic [TAG_W-1:0]             alloc_src2,
    input  logic                         alloc_src2_rdy,
    output logic                         alloc_ready,
    output logic                         issue_valid,
    output logic [1:0]                   issue_op,
    output logic [TAG_W-1:0]             issue_dst,
    output logic [$clog2(ENTRIES)-1:0]   issue_slot,
    output logic [NLANE-1:0]             bcast_valid,
    output logic [NLANE*TAG_W-1:0]       bcast_tag
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] busy, req, grant, alloc_en;
    logic [ENTRIES-1:0] free_oh, req_oh;
    logic [IDX_W-1:0]   free_idx, req_idx;
    logic               free_any, req_any;
    logic [1:0]         slot_op  [ENTRIES];
    logic [TAG_W-1:0]   slot_dst [ENTRIES];

    sched_pick #(.N(ENTRIES), .IW(IDX_W)) u_free_pick (
        .req(~busy), .onehot(free_oh), .idx(free_idx), .any(free_any)
    );

    sched_pick #(.N(ENTRIES), .IW(IDX_W)) u_issue_pick (
        .req(req), .onehot(req_oh), .idx(req_idx), .any(req_any)
    );

    assign alloc_ready = free_any;
    assign alloc_en    = (alloc_valid && free_any && !flush) ? free_oh : '0;
    assign grant       = flush ? '0 : req_oh;
    assign issue_valid = req_any && !flush;
    assign issue_slot  = req_idx;
    assign issue_op    = slot_op[req_idx];
    assign issue_dst   = slot_dst[req_idx];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        sched_slot #(.TAG_W(TAG_W), .NL(NLANE)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .alloc_en (alloc_en[i]),
            .a_op     (alloc_op),
            .a_dst    (alloc_dst),
            .a_s1     (alloc_src1),
            .a_r1     (alloc_src1_rdy),
            .a_s2     (alloc_src2),
            .a_r2     (alloc_src2_rdy),
            .grant    (grant[i]),
            .bc_valid (bcast_valid),
            .bc_tag   (bcast_tag),
            .busy     (busy[i]),
            .req      (req[i]),
            .op_q     (slot_op[i]),
            .dst_q    (slot_dst[i])
        );
    end

    // one delay lane per latency class: at most one push per lane per cycle
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic push;
        assign push = issue_valid && (op_latency(issue_op) == (g + 1));
        sched_lane #(.TAG_W(TAG_W), .DEPTH(g + 1)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_v    (push),
            .in_tag  (issue_dst),
            .out_v   (bcast_valid[g]),
            .out_tag (bcast_tag[g*TAG_W +: TAG_W])
        );
    end
endmodule

// File: rtl/sched_core_chk.sv
module sched_core_chk #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               alloc_ready,
    input logic               issue_valid,
    input logic [1:0]         issue_op,
    input logic [TAG_W-1:0]   issue_dst,
    input logic [3:0]         bcast_valid,
    input logic [4*TAG_W-1:0] bcast_tag,
    input logic [ENTRIES-1:0] grant_vec,
    input logic [ENTRIES-1:0] alloc_en_vec
);
    // R5
    a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R3, R9
    a_r3_alu_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_op == 2'd0) |=>
            (bcast_valid[0] && bcast_tag[TAG_W-1:0] == $past(issue_dst)));

    // R8
    a_r8_load_hit_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_op == 2'd1) |=> ##1
            (bcast_valid[1] && bcast_tag[2*TAG_W-1:TAG_W] == $past(issue_dst, 2)));

    // R7
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (alloc_ready && !issue_valid));

    // R6
    a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_ready |-> (alloc_en_vec == '0));
endmodule

bind sched_core sched_core_chk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .alloc_ready  (alloc_ready),
    .issue_valid  (issue_valid),
    .issue_op     (issue_op),
    .issue_dst    (issue_dst),
    .bcast_valid  (bcast_valid),
    .bcast_tag    (bcast_tag),
    .grant_vec    (grant),
    .alloc_en_vec (alloc_en)
);

// File: tb/sched_core_tb.sv
module sched_core_tb;
    localparam int E  = 4;
    localparam int TW = 5;
    localparam int NL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic alloc_valid = 1'b0;
    logic [1:0] alloc_op = '0;
    logic [TW-1:0] alloc_dst = '0, alloc_src1 = '0, alloc_src2 = '0;
    logic alloc_src1_rdy = 1'b0, alloc_src2_rdy = 1'b0;
    logic alloc_ready, issue_valid;
    logic [1:0] issue_op;
    logic [TW-1:0] issue_dst;
    logic [$clog2(E)-1:0] issue_slot;
    logic [NL-1:0] bcast_valid;
    logic [NL*TW-1:0] bcast_tag;

    always #4 clk = ~clk;

    sched_core #(.ENTRIES(E), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_dst(alloc_dst),
        .alloc_src1(alloc_src1), .alloc_src1_rdy(alloc_src1_rdy),
        .alloc_src2(alloc_src2), .alloc_src2_rdy(alloc_src2_rdy),
        .alloc_ready(alloc_ready), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_dst(issue_dst), .issue_slot(issue_slot),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag)
    );

    int vecs = 0;
    int errs = 0;
    int cyc  = 0;
    int icyc [32];

    // reference model state
    bit          mb  [E];
    bit [1:0]    mop [E];
    bit [TW-1:0] mdst[E], ms1[E], ms2[E];
    bit          mr1 [E], mr2[E];
    bit          lv  [NL][NL];
    bit [TW-1:0] lt  [NL][NL];

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic bit mhit(input bit [TW-1:0] tag);
        mhit = 1'b0;
        for (int g = 0; g < NL; g++)
            if (lv[g][g] && lt[g][g] == tag) mhit = 1'b1;
    endfunction

    function automatic int lat_of(input bit [1:0] op);
        return int'(op) + 1;
    endfunction

    // one cycle: inputs set at the falling edge, outputs judged 2 ns later
    task automatic tick();
        bit e_iv, e_ar;
        int e_idx, f_idx;
        bit [1:0] e_op;
        bit [TW-1:0] e_dst;
        bit h1 [E];
        bit h2 [E];
        bit a1, a2;
        #2;
        for (int g = 0; g < NL; g++) begin
            chk(bcast_valid[g] == lv[g][g], "R3", "bcast_valid lane", int'(bcast_valid[g]), int'(lv[g][g]));
            if (lv[g][g])
                chk(bcast_tag[g*TW +: TW] == lt[g][g], "R3", "bcast_tag lane",
                    int'(bcast_tag[g*TW +: TW]), int'(lt[g][g]));
        end
        e_idx = -1;
        f_idx = -1;
        for (int i = E - 1; i >= 0; i--) begin
            h1[i] = mhit(ms1[i]);
            h2[i] = mhit(ms2[i]);
            if (mb[i] && (mr1[i] || h1[i]) && (mr2[i] || h2[i])) e_idx = i;
            if (!mb[i]) f_idx = i;
        end
        e_iv = (e_idx >= 0) && !flush;
        e_ar = (f_idx >= 0);
        e_op  = (e_idx >= 0) ? mop[e_idx]  : 2'd0;
        e_dst = (e_idx >= 0) ? mdst[e_idx] : '0;
        chk(issue_valid == e_iv, "R5", "issue_valid", int'(issue_valid), int'(e_iv));
        if (e_iv && issue_valid) begin
            chk(issue_slot == e_idx, "R5", "issue_slot", int'(issue_slot), e_idx);
            chk(issue_dst == e_dst, "R2", "issue_dst", int'(issue_dst), int'(e_dst));
            chk(issue_op == e_op, "R2", "issue_op", int'(issue_op), int'(e_op));
        end
        chk(alloc_ready == e_ar, "R6", "alloc_ready", int'(alloc_ready), int'(e_ar));
        if (issue_valid) icyc[issue_dst] = cyc;
        a1 = alloc_src1_rdy || mhit(alloc_src1);
        a2 = alloc_src2_rdy || mhit(alloc_src2);
        @(posedge clk);
        if (flush) begin
            for (int i = 0; i < E; i++) mb[i] = 1'b0;
        end else begin
            for (int i = 0; i < E; i++) begin
                if (mb[i]) begin
                    mr1[i] = mr1[i] || h1[i];
                    mr2[i] = mr2[i] || h2[i];
                end
            end
            if (e_iv) mb[e_idx] = 1'b0;
            if (alloc_valid && e_ar) begin
                mb[f_idx] = 1'b1;   mop[f_idx] = alloc_op;  mdst[f_idx] = alloc_dst;
                ms1[f_idx] = alloc_src1; ms2[f_idx] = alloc_src2;
                mr1[f_idx] = a1;    mr2[f_idx] = a2;
            end
        end
        for (int g = 0; g < NL; g++) begin
            for (int k = g; k >= 1; k--) begin
                lv[g][k] = lv[g][k-1];
                lt[g][k] = lt[g][k-1];
            end
            lv[g][0] = e_iv && (lat_of(e_op) == g + 1);
            lt[g][0] = e_dst;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic put(input bit v, input bit [1:0] op, input bit [TW-1:0] d,
                       input bit [TW-1:0] s1, input bit r1,
                       input bit [TW-1:0] s2, input bit r2);
        alloc_valid = v; alloc_op = op; alloc_dst = d;
        alloc_src1 = s1; alloc_src1_rdy = r1;
        alloc_src2 = s2; alloc_src2_rdy = r2;
        tick();
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) put(1'b0, 2'd0, '0, '0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        int c0;
        for (int i = 0; i < 32; i++) icyc[i] = -1000;
        for (int i = 0; i < E; i++) begin
            mb[i] = 0; mop[i] = 0; mdst[i] = 0; ms1[i] = 0; ms2[i] = 0; mr1[i] = 0; mr2[i] = 0;
        end
        for (int g = 0; g < NL; g++)
            for (int k = 0; k < NL; k++) begin lv[g][k] = 0; lt[g][k] = 0; end

        repeat (3) @(negedge clk);
        #2;
        chk(alloc_ready == 1'b1, "R1", "alloc_ready in reset", int'(alloc_ready), 1);
        chk(issue_valid == 1'b0, "R1", "issue_valid in reset", int'(issue_valid), 0);
        chk(bcast_valid == '0,   "R1", "bcast_valid in reset", int'(bcast_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R11 and R9: ready producer, then back-to-back consumer
        c0 = cyc;
        put(1, 2'd0, 5'd5, 5'd0, 1, 5'd1, 1);
        put(1, 2'd0, 5'd6, 5'd5, 0, 5'd2, 1);
        idle(3);
        chk(icyc[5] == c0 + 1, "R11", "ready-at-alloc issue cycle", icyc[5], c0 + 1);
        chk(icyc[6] - icyc[5] == 1, "R9", "ALU consumer gap", icyc[6] - icyc[5], 1);

        // R8: load consumer woken after the hit latency
        put(1, 2'd1, 5'd7, 5'd0, 1, 5'd0, 1);
        put(1, 2'd0, 5'd8, 5'd7, 0, 5'd7, 0);
        idle(5);
        chk(icyc[8] - icyc[7] == 2, "R8", "load consumer gap", icyc[8] - icyc[7], 2);

        // R3: multiply latency
        put(1, 2'd2, 5'd10, 5'd0, 1, 5'd0, 1);
        put(1, 2'd0, 5'd11, 5'd10, 0, 5'd3, 1);
        idle(6);
        chk(icyc[11] - icyc[10] == 3, "R3", "MUL consumer gap", icyc[11] - icyc[10], 3);

        // R10: consumer allocated in the very cycle of the broadcast
        put(1, 2'd0, 5'd9, 5'd0, 1, 5'd0, 1);
        idle(1);
        put(1, 2'd0, 5'd12, 5'd9, 0, 5'd3, 1);
        idle(3);
        chk(icyc[12] - icyc[9] == 2, "R10", "same-cycle wakeup", icyc[12] - icyc[9], 2);

        // R6 / R7: fill with never-woken entries, try to overfill, flush
        put(1, 2'd0, 5'd13, 5'd31, 0, 5'd31, 0);
        put(1, 2'd0, 5'd14, 5'd31, 0, 5'd31, 0);
        put(1, 2'd0, 5'd15, 5'd31, 0, 5'd31, 0);
        put(1, 2'd0, 5'd16, 5'd31, 0, 5'd31, 0);
        #1;
        chk(alloc_ready == 1'b0, "R6", "alloc_ready when full", int'(alloc_ready), 0);
        @(negedge clk);
        put(1, 2'd0, 5'd30, 5'd0, 1, 5'd0, 1);
        idle(1);
        flush = 1'b1;
        put(1, 2'd0, 5'd30, 5'd0, 1, 5'd0, 1);
        flush = 1'b0;
        idle(1);
        chk(alloc_ready == 1'b1, "R7", "alloc_ready after flush", int'(alloc_ready), 1);
        idle(3);
        chk(icyc[30] < 0, "R6", "blocked allocation never issues", icyc[30], -1000);

        // R5: younger ready entry issues past an older stalled one
        put(1, 2'd0, 5'd17, 5'd31, 0, 5'd31, 0);
        put(1, 2'd0, 5'd18, 5'd0, 1, 5'd0, 1);
        idle(2);
        chk(icyc[18] >= 0, "R5", "out-of-order issue", icyc[18], 1);
        chk(icyc[17] < 0, "R4", "unwoken entry stays", icyc[17], -1000);
        flush = 1'b1;
        idle(1);
        flush = 1'b0;

        // constrained random traffic, judged cycle by cycle by the model
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            flush = (($urandom % 100) == 0);
            put(($urandom % 10) < 6, 2'($urandom % 4), TW'($urandom % 30),
                TW'($urandom % 30), ($urandom % 2) == 1,
                TW'($urandom % 30), ($urandom % 2) == 1);
        end
        flush = 1'b0;
        idle(6);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule